// File: doc/BRIEF.md
# Stretchable Microcycle Timing Controller

This block paces the microinstruction cycle of a microcoded processor. It runs on a base clock whose period is one third of the nominal microcycle. An ordinary microcycle takes three base ticks. The microinstruction in flight can lengthen its own cycle to four ticks. It does this by flagging a conditional microbranch or a slow data path. When it issues a memory access, the cycle is held open until memory answers.

The wait for memory has a bound, set in base ticks by `TMO_TICKS`. The default is 48 ticks, roughly 2 µs at a 125 ns microcycle. If memory stays silent for the whole window, the controller ends the cycle anyway and latches a request-timeout interrupt. That interrupt holds until software clears it. The sequencer advances on the one-tick end strobe, and the wait output marks the ticks spent stalled on memory.

The phase machine has five states:
- `PH_A` and `PH_B` are the first and second ticks of every cycle.
- `PH_C` is the third tick, where the decision is taken.
- `PH_X` is the extra fourth tick of a stretched cycle.
- `MEM_WAIT` holds the cycle for memory.

The transitions are:
- `PH_A`→`PH_B`→`PH_C`.
- `PH_C`→`MEM_WAIT` on an unanswered memory request.
- `PH_C`→`PH_X` on a stretch request.
- `PH_C`→`PH_A` otherwise, ending the cycle.
- `PH_X`→`PH_A`, ending the cycle.
- `MEM_WAIT`→`PH_A` on acknowledge or when the wait window expires, ending the cycle.
- `MEM_WAIT`→`MEM_WAIT` while neither occurs.

Top module: `mc_cycle_timer`

## Requirements
- R1: While `rst_n` is low, and on the first tick after it rises, `cyc_end`, `mem_wait` and `tmo_irq` are low. The first tick after reset is tick 1 of a new microcycle.
- R2: With no stretch flag and no memory request at tick 3, the microcycle lasts 3 ticks, and `cyc_end` is high during tick 3.
- R3: With `br_cond` or `slow_path` (or both) high at tick 3 and no unanswered memory request, the microcycle lasts 4 ticks, and `cyc_end` is high during tick 4.
- R4: `cyc_end` is high for exactly one tick per microcycle. The tick after it is tick 1 of the next microcycle, with `cyc_end` low.
- R5: If `mem_req` and `mem_ack` are both high at tick 3, there is no wait. The length then follows R2/R3.
- R6: If `mem_req` is high and `mem_ack` low at tick 3, `mem_wait` is high from tick 4 through the tick where the cycle ends. The cycle ends in the first wait tick with `mem_ack` high. Stretch flags add nothing to such a cycle.
- R7: If no acknowledge arrives in `TMO_TICKS` wait ticks, the cycle ends on the last of them (length 3+`TMO_TICKS`). `tmo_irq` is high from the following tick.
- R8: An acknowledge on the last permitted wait tick wins over the timeout. The cycle ends normally and `tmo_irq` is not set.
- R9: `tmo_irq` stays high until `tmo_clr` is high for a tick. It is then low from the following tick.
- R10: When a timeout and `tmo_clr` fall on the same tick, the timeout wins and `tmo_irq` is high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base tick clock (one third of a microcycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_cond | input | 1 | Current microinstruction is a conditional branch |
| slow_path | input | 1 | Current microinstruction needs the long data path |
| mem_req | input | 1 | Current microinstruction accesses memory |
| mem_ack | input | 1 | Memory has answered |
| tmo_clr | input | 1 | Clears the timeout interrupt |
| cyc_end | output | 1 | One-tick strobe on the final tick of each microcycle |
| mem_wait | output | 1 | Cycle is held waiting for memory |
| tmo_irq | output | 1 | Sticky request-timeout interrupt |

## Verification
The assertions assume these properties of the inputs:
- The sequencer holds `br_cond`, `slow_path` and `mem_req` steady for a whole microcycle.
- `mem_ack`, once raised inside a cycle, stays high until that cycle ends.

The stimulus changes the per-cycle inputs only on the tick after `cyc_end`, and keeps each acknowledge high from its arrival tick onward. Random arrival ticks are drawn from before tick 3 to well past the timeout window. Directed cases place the acknowledge on tick 3, on the first wait tick and on the last wait tick. They also raise a clear on the very tick a timeout fires.

// File: rtl/mc_timer_pkg.sv
package mc_timer_pkg;
    typedef enum logic [2:0] {
        PH_A     = 3'd0,
        PH_B     = 3'd1,
        PH_C     = 3'd2,
        PH_X     = 3'd3,
        MEM_WAIT = 3'd4
    } mc_phase_e;
endpackage

// File: rtl/mc_wait_timer.sv
module mc_wait_timer #(
    parameter int TMO_TICKS = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic waiting,
    output logic expired
);
    localparam int CW = $clog2(TMO_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!waiting)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        expired = waiting && (cnt_q == LAST);
    end

    // R7
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> (cnt_q <= LAST));

    // R7
    wait_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(waiting) |-> (cnt_q == '0));
endmodule

// File: rtl/mc_phase_fsm.sv
module mc_phase_fsm
    import mc_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stretch,
    input  logic mem_req,
    input  logic mem_ack,
    input  logic expired,
    output logic cyc_end,
    output logic mem_wait,
    output logic tmo_set
);
    mc_phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PH_A;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_A: state_d = PH_B;
            PH_B: state_d = PH_C;
            PH_C: begin
                if (mem_req && !mem_ack)
                    state_d = MEM_WAIT;
                else if (stretch)
                    state_d = PH_X;
                else
                    state_d = PH_A;
            end
            PH_X: state_d = PH_A;
            MEM_WAIT: begin
                if (mem_ack || expired)
                    state_d = PH_A;
            end
            default: state_d = PH_A;
        endcase
    end

    always_comb begin
        cyc_end  = 1'b0;
        tmo_set  = 1'b0;
        mem_wait = 1'b0;
        unique case (state_q)
            PH_A, PH_B: ;
            PH_C:
                cyc_end = !(mem_req && !mem_ack) && !stretch;
            PH_X:
                cyc_end = 1'b1;
            MEM_WAIT: begin
                mem_wait = 1'b1;
                cyc_end  = mem_ack || expired;
                tmo_set  = !mem_ack && expired;
            end
            default: ;
        endcase
    end

    // R4
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> !cyc_end);

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> (state_q == PH_A));

    // R6
    wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wait && !cyc_end) |=> mem_wait);
endmodule

// File: rtl/mc_irq_latch.sv
module mc_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (set_i)
            irq <= 1'b1;
        else if (clr_i)
            irq <= 1'b0;
    end

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_i) |=> irq);

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !irq);

    // R10
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> irq);
endmodule

// File: rtl/mc_cycle_timer.sv
module mc_cycle_timer #(
    parameter int TMO_TICKS = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic br_cond,
    input  logic slow_path,
    input  logic mem_req,
    input  logic mem_ack,
    input  logic tmo_clr,
    output logic cyc_end,
    output logic mem_wait,
    output logic tmo_irq
);
    logic stretch;
    logic expired;
    logic tmo_set;

    always_comb begin
        stretch = br_cond || slow_path;
    end

    mc_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stretch  (stretch),
        .mem_req  (mem_req),
        .mem_ack  (mem_ack),
        .expired  (expired),
        .cyc_end  (cyc_end),
        .mem_wait (mem_wait),
        .tmo_set  (tmo_set)
    );

    mc_wait_timer #(.TMO_TICKS(TMO_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .waiting (mem_wait),
        .expired (expired)
    );

    mc_irq_latch u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (tmo_set),
        .clr_i (tmo_clr),
        .irq   (tmo_irq)
    );

    // R8
    ack_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wait && mem_ack && !tmo_irq) |=> !tmo_irq);

    // R7
    tmo_needs_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_irq) |-> $past(mem_wait && cyc_end && !mem_ack));
endmodule

// File: tb/tb_mc_cycle_timer.sv
module tb_mc_cycle_timer;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic br_cond = 1'b0, slow_path = 1'b0, mem_req = 1'b0, mem_ack = 1'b0, tmo_clr = 1'b0;
    logic cyc_end, mem_wait, tmo_irq;

    int n_checks = 0;
    int n_fail = 0;
    logic irq_exp = 1'b0;
    string irq_tag = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_cycle_timer #(.TMO_TICKS(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .br_cond(br_cond), .slow_path(slow_path),
        .mem_req(mem_req), .mem_ack(mem_ack), .tmo_clr(tmo_clr),
        .cyc_end(cyc_end), .mem_wait(mem_wait), .tmo_irq(tmo_irq)
    );

    function automatic int exp_len(bit c, bit p, bit rq, int ack_at);
        if (!rq || ack_at <= 3) return 3 + ((c || p) ? 1 : 0);
        if (ack_at - 3 <= TMO) return ack_at;
        return 3 + TMO;
    endfunction

    function automatic bit exp_tmo(bit rq, int ack_at);
        return rq && (ack_at > 3 + TMO);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One microcycle, starting at a negedge at tick 1.
    task automatic run_cycle(bit c, bit p, bit rq, int ack_at, bit clr, string tag);
        int len_e = exp_len(c, p, rq, ack_at);
        bit tmo_e = exp_tmo(rq, ack_at);
        bit want_wait = rq && (ack_at > 3);
        int wait_bad = 0;
        int t = 1;
        br_cond = c; slow_path = p; mem_req = rq; tmo_clr = clr;
        mem_ack = rq && (t >= ack_at);
        #1;
        check(tmo_irq == irq_exp, irq_tag, tmo_irq, irq_exp);
        check(!cyc_end || len_e == 1, "R4", cyc_end, 0);
        forever begin
            if (mem_wait != (want_wait && t >= 4)) wait_bad++;
            if (cyc_end) break;
            if (t > 3 + TMO + 8) break;
            @(negedge clk);
            t++;
            mem_ack = rq && (t >= ack_at);
            #1;
        end
        check(t == len_e && cyc_end, tag, t, len_e);
        check(wait_bad == 0, "R6", wait_bad, 0);
        irq_tag = "R9";
        if (tmo_e) begin
            irq_exp = 1'b1;
            if (clr) irq_tag = "R10";
            else irq_tag = "R7";
        end else if (clr) begin
            irq_exp = 1'b0;
        end else if (rq && ack_at == 3 + TMO) begin
            irq_tag = "R8";
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        #1;
        check(!cyc_end && !mem_wait && !tmo_irq, "R1", {cyc_end, mem_wait, tmo_irq}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first tick after release is tick 1; checked inside the cycle
        run_cycle(0, 0, 0, 0, 0, "R1");
        run_cycle(0, 0, 0, 0, 0, "R2");
        run_cycle(1, 0, 0, 0, 0, "R3");
        run_cycle(0, 1, 0, 0, 0, "R3");
        run_cycle(1, 1, 0, 0, 0, "R3");
        run_cycle(0, 0, 1, 3, 0, "R5");
        run_cycle(0, 1, 1, 2, 0, "R5");
        run_cycle(0, 0, 1, 4, 0, "R6");
        run_cycle(1, 1, 1, 10, 0, "R6");
        run_cycle(0, 0, 1, 3 + TMO, 0, "R8");
        run_cycle(0, 0, 1, 3 + TMO, 0, "R8");
        run_cycle(0, 0, 1, 1000, 0, "R7");
        run_cycle(0, 0, 0, 0, 0, "R9");
        run_cycle(1, 0, 0, 0, 1, "R9");
        run_cycle(0, 0, 0, 0, 0, "R9");
        run_cycle(0, 0, 1, 1000, 1, "R10");
        run_cycle(0, 0, 0, 0, 0, "R10");
        run_cycle(0, 0, 0, 0, 1, "R9");
        for (int i = 0; i < 250; i++) begin
            bit c = 1'($urandom_range(0, 1));
            bit p = 1'($urandom_range(0, 1));
            bit rq = 1'($urandom_range(0, 1));
            int a = int'($urandom_range(1, TMO + 8));
            bit clr = ($urandom_range(0, 7) == 0);
            run_cycle(c, p, rq, a, clr,
                      rq ? ((a > 3 + TMO) ? "R7" : "R6") : ((c || p) ? "R3" : "R2"));
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule